// File: doc/BRIEF.md
# Flowlet-Aware Uplink Selector

This block sits on the egress side of a leaf switch and picks one of several spine uplinks for every packet descriptor it accepts. A direct-mapped flow table remembers, for each flow, the uplink in use and the timestamp of its most recent packet. A packet that arrives after a quiet period longer than a programmable gap threshold opens a new flowlet. Only then may the flow move, and it moves to the next uplink, in round-robin order, whose most recent buffer-occupancy report was below a congestion threshold. Packets inside a flowlet stay on one uplink, so they cannot be reordered by the fabric.

A programmable share of flows is never adapted. These static flows are pinned to the source rank modulo the uplink count, which spreads static traffic evenly over the uplinks. Occupancy reports arrive late and one uplink at a time, and the selector acts on the last stored congestion flag of each uplink. The block keeps a clearable count of re-route events.

Top module: `flowlet_uplink_sel`

## Requirements
- R1: While reset is asserted `desc_ready` is 0. After reset `sel_valid` is 0 and `reroute_cnt` is 0, and `desc_ready` is 1 from the first clock edge after reset is released.
- R2: A descriptor is accepted on a clock edge where `desc_valid` and `desc_ready` are both 1. `sel_valid` is 1 in the cycle after an acceptance and 0 in the cycle after any cycle without one.
- R3: The flow table has 64 entries indexed by `desc_flow[5:0]`, and each entry stores the full flow ID. A descriptor whose flow ID does not match the stored entry, or whose entry has never been written, is a new flow. It is sent to uplink `desc_rank % 8` and does not count as a re-route.
- R4: For an adaptive flow already in the table, the uplink stays unchanged when the modular gap `ts_now - last_ts` is less than or equal to `cfg_gap_thr`.
- R5: For an adaptive flow already in the table with a gap greater than `cfg_gap_thr`, the new uplink is the first uplink in the order cur+1, cur+2, ... (modulo 8) whose congestion flag is clear. If all other uplinks are congested, the current uplink is kept.
- R6: An occupancy report (`occ_valid`, `occ_port`, `occ_pct`) sets that uplink's congestion flag when `occ_pct > cfg_cong_thr` and clears it otherwise. The flag is held until the next report for the same uplink. A descriptor accepted in the same cycle as a report uses the flag as it was before that report.
- R7: Hash h is 3 bits, where bit b is the XOR of all `desc_flow` bits whose index modulo 3 equals b. A flow is static when h >= `cfg_adapt_eighths` (0 to 8). A static flow always goes to `desc_rank % 8` and never counts as a re-route.
- R8: `cfg_err` is 1 exactly when `cfg_gap_thr <= cfg_reorder`. While it is 1 no flowlet boundary is detected, so flows already in the table keep their uplink.
- R9: The gap is computed modulo 2^32, so a timestamp that wraps past zero gives the correct elapsed time.
- R10: A re-route is a flowlet boundary that changes the uplink. It raises `sel_reroute` together with `sel_valid` and increments `reroute_cnt` one cycle after acceptance. `cnt_clear` zeroes the counter on the next edge and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_flow | input | 16 | Flow identifier |
| desc_rank | input | 8 | Source rank of the packet |
| ts_now | input | 32 | Free-running timestamp |
| occ_valid | input | 1 | Occupancy report present |
| occ_port | input | 3 | Uplink the report describes |
| occ_pct | input | 7 | Buffer occupancy in percent |
| cfg_gap_thr | input | 32 | Flowlet gap threshold |
| cfg_reorder | input | 32 | Receiver reorder-timer value |
| cfg_cong_thr | input | 7 | Congestion threshold in percent (60 typical, 50 to 70) |
| cfg_adapt_eighths | input | 4 | Adaptive share in eighths, 0 to 8 |
| cfg_err | output | 1 | Gap threshold not above reorder timer |
| sel_valid | output | 1 | Decision present |
| sel_uplink | output | 3 | Chosen uplink |
| sel_reroute | output | 1 | Decision moved the flow |
| cnt_clear | input | 1 | Clear the re-route counter |
| reroute_cnt | output | 16 | Re-route events since reset or clear |

## Verification
Each decision (`sel_valid`, `sel_uplink`, `sel_reroute`) and the counter step it causes are due one edge after acceptance. An occupancy report first affects a descriptor accepted one edge after the report. `cfg_err` follows the configuration inputs without a register. The bench drives inputs on the falling edge and updates its model of the table and flags at that moment, using the flags as they were before that cycle's report. It compares against the outputs at the next falling edge, exactly one rising edge later, so every result is sampled in the cycle it is due.

// File: rtl/flowlet_sel_pkg.sv
`timescale 1ns/1ps
package flowlet_sel_pkg;
  // classification of one accepted descriptor
  typedef struct packed {
    logic hit;       // table entry belongs to this flow
    logic adaptive;  // flow may be moved
    logic boundary;  // gap long enough to open a flowlet
  } flow_class_t;
endpackage

// File: rtl/flowlet_cong_flags.sv
`timescale 1ns/1ps
module flowlet_cong_flags #(
  parameter int N_UP  = 8,
  parameter int PCT_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    occ_valid,
  input  logic [$clog2(N_UP)-1:0] occ_port,
  input  logic [PCT_W-1:0]        occ_pct,
  input  logic [PCT_W-1:0]        cfg_thr,
  output logic [N_UP-1:0]         cong
);
  localparam int IDX_W = $clog2(N_UP);

  logic hot;
  assign hot = occ_pct > cfg_thr;

  for (genvar u = 0; u < N_UP; u++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)
        cong[u] <= 1'b0;
      else if (occ_valid && occ_port == IDX_W'(u))
        cong[u] <= hot;
    end
  end

  // R6: a report lands in its uplink's flag on the next edge
  a_r6_flag_tracks_report: assert property (@(posedge clk) disable iff (!rst_n)
    occ_valid |=> cong[$past(occ_port)] == ($past(occ_pct) > $past(cfg_thr)));
endmodule

// File: rtl/flowlet_rr_pick.sv
`timescale 1ns/1ps
module flowlet_rr_pick #(
  parameter int N_UP = 8
) (
  input  logic [$clog2(N_UP)-1:0] cur,
  input  logic [N_UP-1:0]         cong,
  output logic [$clog2(N_UP)-1:0] pick,
  output logic                    any_free
);
  localparam int IDX_W = $clog2(N_UP);

  // scan cur+1 .. cur+N_UP-1, first clear flag wins
  always_comb begin
    pick     = cur;
    any_free = 1'b0;
    for (int k = 1; k < N_UP; k++) begin
      logic [IDX_W-1:0] cand;
      cand = IDX_W'((int'(cur) + k) % N_UP);
      if (!any_free && !cong[cand]) begin
        pick     = cand;
        any_free = 1'b1;
      end
    end
  end
endmodule

// File: rtl/flowlet_flow_table.sv
`timescale 1ns/1ps
module flowlet_flow_table #(
  parameter int DEPTH  = 64,
  parameter int FLOW_W = 16,
  parameter int UP_W   = 3,
  parameter int TS_W   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic                     rd_vld,
  output logic [FLOW_W-1:0]        rd_tag,
  output logic [UP_W-1:0]          rd_up,
  output logic [TS_W-1:0]          rd_ts,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [FLOW_W-1:0]        wr_tag,
  input  logic [UP_W-1:0]          wr_up,
  input  logic [TS_W-1:0]          wr_ts
);
  logic [DEPTH-1:0]  vld_q;
  logic [FLOW_W-1:0] tag_q [DEPTH];
  logic [UP_W-1:0]   up_q  [DEPTH];
  logic [TS_W-1:0]   ts_q  [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)
      vld_q <= '0;
    else if (wr_en)
      vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      up_q[wr_idx]  <= wr_up;
      ts_q[wr_idx]  <= wr_ts;
    end
  end

  assign rd_vld = vld_q[rd_idx];
  assign rd_tag = tag_q[rd_idx];
  assign rd_up  = up_q[rd_idx];
  assign rd_ts  = ts_q[rd_idx];
endmodule

// File: rtl/flowlet_uplink_sel.sv
`timescale 1ns/1ps
module flowlet_uplink_sel
  import flowlet_sel_pkg::*;
#(
  parameter int N_UP   = 8,
  parameter int DEPTH  = 64,
  parameter int FLOW_W = 16,
  parameter int RANK_W = 8,
  parameter int TS_W   = 32,
  parameter int PCT_W  = 7,
  parameter int CNT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      desc_valid,
  output logic                      desc_ready,
  input  logic [FLOW_W-1:0]         desc_flow,
  input  logic [RANK_W-1:0]         desc_rank,
  input  logic [TS_W-1:0]           ts_now,
  input  logic                      occ_valid,
  input  logic [$clog2(N_UP)-1:0]   occ_port,
  input  logic [PCT_W-1:0]          occ_pct,
  input  logic [TS_W-1:0]           cfg_gap_thr,
  input  logic [TS_W-1:0]           cfg_reorder,
  input  logic [PCT_W-1:0]          cfg_cong_thr,
  input  logic [$clog2(N_UP):0]     cfg_adapt_eighths,
  output logic                      cfg_err,
  output logic                      sel_valid,
  output logic [$clog2(N_UP)-1:0]   sel_uplink,
  output logic                      sel_reroute,
  input  logic                      cnt_clear,
  output logic [CNT_W-1:0]          reroute_cnt
);
  localparam int IDX_W  = $clog2(N_UP);
  localparam int TIDX_W = $clog2(DEPTH);

  // XOR fold of the flow ID into IDX_W bits (bit b gathers indices i%IDX_W==b)
  function automatic logic [IDX_W-1:0] fold_flow(input logic [FLOW_W-1:0] f);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < FLOW_W; i++)
      h[i % IDX_W] = h[i % IDX_W] ^ f[i];
    return h;
  endfunction

  // elapsed time modulo 2^TS_W
  function automatic logic [TS_W-1:0] mod_gap(input logic [TS_W-1:0] now,
                                              input logic [TS_W-1:0] last);
    return now - last;
  endfunction

  function automatic logic [IDX_W-1:0] home_of(input logic [RANK_W-1:0] r);
    return IDX_W'(r % RANK_W'(N_UP));
  endfunction

  // ---------------- named internal events ----------------
  logic              acc;
  logic              rd_vld;
  logic [FLOW_W-1:0] rd_tag;
  logic [IDX_W-1:0]  rd_up;
  logic [TS_W-1:0]   rd_ts;
  logic [N_UP-1:0]   cong;
  logic [IDX_W-1:0]  pick;
  logic              any_free;
  logic [IDX_W-1:0]  home;
  logic [IDX_W-1:0]  next_up;
  logic [TS_W-1:0]   gap;
  flow_class_t       cls;
  logic              reroute_evt;
  logic              ready_q;

  assign desc_ready = ready_q;
  assign acc        = desc_valid && ready_q;
  assign cfg_err    = cfg_gap_thr <= cfg_reorder;
  assign home       = home_of(desc_rank);
  assign gap        = mod_gap(ts_now, rd_ts);

  assign cls.hit      = rd_vld && (rd_tag == desc_flow);
  assign cls.adaptive = {1'b0, fold_flow(desc_flow)} < cfg_adapt_eighths;
  assign cls.boundary = cls.hit && cls.adaptive && !cfg_err && (gap > cfg_gap_thr);

  always_comb begin
    if (!cls.hit || !cls.adaptive) next_up = home;
    else if (cls.boundary)         next_up = pick;
    else                           next_up = rd_up;
  end

  assign reroute_evt = acc && cls.boundary && (pick != rd_up);

  flowlet_flow_table #(
    .DEPTH(DEPTH), .FLOW_W(FLOW_W), .UP_W(IDX_W), .TS_W(TS_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(desc_flow[TIDX_W-1:0]),
    .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_up(rd_up), .rd_ts(rd_ts),
    .wr_en(acc), .wr_idx(desc_flow[TIDX_W-1:0]),
    .wr_tag(desc_flow), .wr_up(next_up), .wr_ts(ts_now)
  );

  flowlet_cong_flags #(.N_UP(N_UP), .PCT_W(PCT_W)) u_cong (
    .clk(clk), .rst_n(rst_n),
    .occ_valid(occ_valid), .occ_port(occ_port), .occ_pct(occ_pct),
    .cfg_thr(cfg_cong_thr), .cong(cong)
  );

  flowlet_rr_pick #(.N_UP(N_UP)) u_pick (
    .cur(rd_up), .cong(cong), .pick(pick), .any_free(any_free)
  );

  // ---------------- registered outputs ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      sel_valid   <= 1'b0;
      sel_uplink  <= '0;
      sel_reroute <= 1'b0;
      reroute_cnt <= '0;
    end else begin
      ready_q     <= 1'b1;
      sel_valid   <= acc;
      sel_reroute <= reroute_evt;
      if (acc) sel_uplink <= next_up;
      if (cnt_clear)        reroute_cnt <= '0;
      else if (reroute_evt) reroute_cnt <= reroute_cnt + 1'b1;
    end
  end

  // ---------------- assertions ----------------
  a_r2_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> sel_valid);
  a_r2_quiet_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !sel_valid);
  a_r4_keep_inside_flowlet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cls.hit && cls.adaptive && !cls.boundary) |=> (sel_uplink == $past(rd_up) && !sel_reroute));
  a_r5_pick_is_free: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cls.boundary && any_free) |-> !cong[pick]);
  a_r5_all_busy_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cls.boundary && !any_free) |=> sel_uplink == $past(rd_up));
  a_r8_no_move_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cfg_err) |=> !sel_reroute);
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> reroute_cnt == '0);
  a_r10_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clear && !reroute_evt) |=> $stable(reroute_cnt));
endmodule

// File: tb/flowlet_uplink_sel_test.sv
`timescale 1ns/1ps
module flowlet_uplink_sel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_valid = 1'b0;
  logic        desc_ready;
  logic [15:0] desc_flow = '0;
  logic [7:0]  desc_rank = '0;
  logic [31:0] ts_now = '0;
  logic        occ_valid = 1'b0;
  logic [2:0]  occ_port = '0;
  logic [6:0]  occ_pct = '0;
  logic [31:0] cfg_gap_thr = 32'd100;
  logic [31:0] cfg_reorder = 32'd40;
  logic [6:0]  cfg_cong_thr = 7'd60;
  logic [3:0]  cfg_adapt_eighths = 4'd8;
  logic        cfg_err;
  logic        sel_valid;
  logic [2:0]  sel_uplink;
  logic        sel_reroute;
  logic        cnt_clear = 1'b0;
  logic [15:0] reroute_cnt;

  flowlet_uplink_sel uut (.*);

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  logic        m_vld [64];
  logic [15:0] m_tag [64];
  logic [2:0]  m_up  [64];
  logic [31:0] m_ts  [64];
  logic        m_cong [8];
  logic [15:0] m_cnt = '0;
  logic [31:0] ts = '0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] b_hash(input logic [15:0] f);
    logic [2:0] h = '0;
    for (int c = 0; c < 16; c += 3)
      for (int b = 0; b < 3; b++)
        if (c + b < 16) h[b] ^= f[c + b];
    return h;
  endfunction

  // one cycle: drive at falling edge, compare one rising edge later
  task automatic step(input logic dv, input logic [15:0] fl, input logic [7:0] rk,
                      input int dts, input logic ov, input logic [2:0] op,
                      input logic [6:0] opct, input logic clr);
    logic [2:0] e_up = '0;
    logic       e_rr = 1'b0;
    string      req = "R3";
    ts = ts + 32'(dts);
    desc_valid = dv; desc_flow = fl; desc_rank = rk; ts_now = ts;
    occ_valid = ov; occ_port = op; occ_pct = opct; cnt_clear = clr;
    if (dv) begin
      int         ix   = int'(fl[5:0]);
      logic       hit  = m_vld[ix] && m_tag[ix] == fl;
      logic       stat = {1'b0, b_hash(fl)} >= cfg_adapt_eighths;
      logic [2:0] home = 3'(rk % 8);
      logic       err  = cfg_gap_thr <= cfg_reorder;
      if (!hit) begin e_up = home; req = "R3"; end
      else if (stat) begin e_up = home; req = "R7"; end
      else if (!err && (ts - m_ts[ix]) > cfg_gap_thr) begin
        logic found = 1'b0;
        e_up = m_up[ix];
        for (int k = 1; k < 8; k++) begin
          logic [2:0] c = 3'((int'(m_up[ix]) + k) & 7);
          if (!found && !m_cong[c]) begin e_up = c; found = 1'b1; end
        end
        e_rr = e_up != m_up[ix];
        req = "R5";
      end else begin
        e_up = m_up[ix];
        req = err ? "R8" : "R4";
      end
      m_vld[ix] = 1'b1; m_tag[ix] = fl; m_up[ix] = e_up; m_ts[ix] = ts;
    end
    if (ov) m_cong[op] = opct > cfg_cong_thr;
    if (clr) m_cnt = '0;
    else if (e_rr) m_cnt = m_cnt + 16'd1;
    @(posedge clk);
    @(negedge clk);
    chk("R2", "sel_valid", sel_valid, dv);
    if (dv) begin
      chk(req, "sel_uplink", sel_uplink, e_up);
      chk("R10", "sel_reroute", sel_reroute, e_rr);
    end
    chk("R10", "reroute_cnt", reroute_cnt, m_cnt);
    chk("R8", "cfg_err", cfg_err, cfg_gap_thr <= cfg_reorder);
  endtask

  task automatic desc(input logic [15:0] fl, input logic [7:0] rk, input int dts);
    step(1'b1, fl, rk, dts, 1'b0, 3'd0, 7'd0, 1'b0);
  endtask

  task automatic occ(input logic [2:0] p, input logic [6:0] pct);
    step(1'b0, 16'd0, 8'd0, 1, 1'b1, p, pct, 1'b0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
    for (int i = 0; i < 8; i++) m_cong[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "desc_ready in reset", desc_ready, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", "desc_ready after reset", desc_ready, 1);
    chk("R1", "sel_valid after reset", sel_valid, 0);
    chk("R1", "reroute_cnt after reset", reroute_cnt, 0);

    // new flow, keep, boundary
    desc(16'h0005, 8'd13, 10);
    chk("R3", "new flow home", sel_uplink, 5);
    desc(16'h0005, 8'd13, 100);
    chk("R4", "gap equal to threshold keeps", sel_uplink, 5);
    desc(16'h0005, 8'd13, 101);
    chk("R5", "boundary moves", sel_uplink, 6);
    chk("R10", "count after move", reroute_cnt, 1);
    // congestion, threshold edge at exactly 60
    occ(3'd7, 7'd61); occ(3'd0, 7'd61); occ(3'd1, 7'd60);
    desc(16'h0005, 8'd13, 150);
    chk("R6", "skip congested 7 and 0", sel_uplink, 1);
    // report and descriptor in one cycle: old flag used
    step(1'b1, 16'h0005, 8'd13, 150, 1'b1, 3'd2, 7'd90, 1'b0);
    chk("R6", "same-cycle report not seen", sel_uplink, 2);
    for (int p = 0; p < 8; p++) occ(3'(p), 7'd95);
    desc(16'h0005, 8'd13, 200);
    chk("R5", "all congested keeps", sel_uplink, 2);
    for (int p = 0; p < 8; p++) occ(3'(p), 7'd10);
    // alias into same slot
    desc(16'h0045, 8'd2, 5);
    chk("R3", "aliased flow is new", sel_uplink, 2);
    // static share
    cfg_adapt_eighths = 4'd0;
    desc(16'h0045, 8'd10, 300);
    chk("R7", "static pinned to rank", sel_uplink, 2);
    // configuration error
    cfg_adapt_eighths = 4'd8; cfg_reorder = 32'd100;
    desc(16'h0045, 8'd10, 500);
    chk("R8", "no move on bad config", sel_uplink, 2);
    cfg_reorder = 32'd40;
    // timestamp wrap
    ts = 32'hFFFF_FFF0;
    desc(16'h0009, 8'd4, 0);
    desc(16'h0009, 8'd4, 48);
    chk("R9", "wrapped gap 48 keeps", sel_uplink, 4);
    desc(16'h0009, 8'd4, 101);
    chk("R9", "wrapped gap 101 moves", sel_uplink, 5);
    // clear beats a same-cycle move
    step(1'b1, 16'h0009, 8'd4, 150, 1'b0, 3'd0, 7'd0, 1'b1);
    chk("R10", "clear wins", reroute_cnt, 0);
    step(1'b0, 16'd0, 8'd0, 1, 1'b0, 3'd0, 7'd0, 1'b0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] ratios [4] = '{4'd0, 4'd3, 4'd7, 4'd8};
      int dts;
      if (n % 500 == 0) cfg_adapt_eighths = ratios[(n / 500) % 4];
      dts = ($urandom_range(0, 9) == 0) ? int'($urandom_range(150, 400))
                                        : int'($urandom_range(0, 120));
      step($urandom_range(0, 9) < 8, 16'($urandom_range(0, 95)), 8'($urandom_range(0, 255)),
           dts, $urandom_range(0, 9) < 3, 3'($urandom_range(0, 7)),
           7'($urandom_range(40, 80)), $urandom_range(0, 49) == 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule